// File: doc/BRIEF.md
# Serial-Link PLL Divider Calculator

This block turns a requested per-lane serial bit rate, given in Hz as a 32-bit unsigned number, into the settings a transmit PLL needs. A threshold table first classifies the rate into one of five power-of-two output divide factors. Each factor comes with a pair of 2-bit select codes. The block then computes a fixed-point frequency control word against a fixed 26 MHz reference clock. It also reports the request clamped into the serviceable rate window, and it raises an error flag for rates that are too slow.

The block is used with a simple handshake. The caller holds the rate on `rate_i` and pulses `start_i` for one cycle. The block raises `busy_o`. When `done_o` pulses, all result outputs are valid, and they hold until the next result. The control word is produced by a sequential restoring divider that resolves one quotient bit per clock, so a valid request takes about 66 cycles. A rejected request completes in two cycles.

Top module: `pllcalc_top`

## Requirements
- R1: A rate of 500,000,000 or more selects divide 1: `div_onehot_o` = 5'b00001 and `sel_o` = 4'b0000.
- R2: A rate of at least 250,000,000 and below 500,000,000 selects divide 2: `div_onehot_o` = 5'b00010 and `sel_o` = 4'b0001.
- R3: A rate of at least 125,000,000 and below 250,000,000 selects divide 4: `div_onehot_o` = 5'b00100 and `sel_o` = 4'b0010.
- R4: A rate strictly above 62,000,000 and below 125,000,000 selects divide 8: `div_onehot_o` = 5'b01000 and `sel_o` = 4'b0110. A rate of exactly 62,000,000 does not fall in this band.
- R5: A rate from 50,000,000 up to and including 62,000,000 selects divide 16: `div_onehot_o` = 5'b10000 and `sel_o` = 4'b1010.
- R6: A rate below 50,000,000 completes with `err_o` = 1, `fcw_o` = 0, `div_onehot_o` = 0 and `sel_o` = 0. A valid rate completes with `err_o` = 0.
- R7: For a valid rate, `fcw_o` equals bits 30:0 of floor(((rate × 2 × div) << 24) / 26,000,000), with the dividend formed at 64 bits. Bits 30:24 are the integer part and bits 23:0 are the fraction.
- R8: `rounded_o` equals the requested rate clamped to the range 50,000,000 to 1,250,000,000, and is updated with every result.
- R9: Accepting `start_i` raises `busy_o` on the next cycle. Each accepted start yields exactly one single-cycle `done_o` pulse. `busy_o` is low in the cycle where `done_o` is high.
- R10: A `start_i` pulse while `busy_o` is high is ignored: it produces no extra result, and the running result still reflects the rate that was accepted.
- R11: After reset, `busy_o`, `done_o`, `err_o`, `fcw_o`, `div_onehot_o`, `sel_o` and `rounded_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe, accepted only while idle |
| rate_i | input | 32 | Requested lane rate in Hz, sampled at start |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| err_o | output | 1 | Rate below the serviceable minimum |
| fcw_o | output | 31 | Control word, 7 integer and 24 fraction bits |
| div_onehot_o | output | 5 | One-hot divide factor, bit i means divide by 2^i |
| sel_o | output | 4 | Select codes packed as {field1, field0} |
| rounded_o | output | 32 | Rate clamped to the serviceable window |

## Verification
Several properties are checked on every cycle by the embedded assertions. These include the single-cycle nature of `done_o` and its exclusion with `busy_o`, the freezing of the captured rate while a start arrives during a busy period, and the clamp window of `rounded_o`. They also cover the all-zero result on an error, the one-hot divide on success, and the restoring-divider invariant that the partial remainder stays below the reference. The exact band edges can only be shown by the bench's scenarios: 62,000,000 falling to divide 16, and 499,999,999 versus 500,000,000. The same holds for the bit-exact control-word values and for the absence of a second result after an ignored start.

// File: rtl/pllcalc_pkg.sv
package pllcalc_pkg;
  localparam int unsigned SHAMT_W = 3;

  typedef struct packed {
    logic                err;
    logic [4:0]          div_oh;
    logic [1:0]          f1;
    logic [1:0]          f0;
    logic [SHAMT_W-1:0]  shamt;
  } divsel_t;
endpackage

// File: rtl/pllcalc_classify.sv
module pllcalc_classify
  import pllcalc_pkg::*;
#(
  parameter int unsigned RATE_W  = 32,
  parameter longint unsigned TH_D1  = 500000000,
  parameter longint unsigned TH_D2  = 250000000,
  parameter longint unsigned TH_D4  = 125000000,
  parameter longint unsigned TH_D8X = 62000000,
  parameter longint unsigned TH_MIN = 50000000
) (
  input  logic [RATE_W-1:0] rate,
  output divsel_t           cls
);
  localparam logic [RATE_W-1:0] L1 = RATE_W'(TH_D1);
  localparam logic [RATE_W-1:0] L2 = RATE_W'(TH_D2);
  localparam logic [RATE_W-1:0] L4 = RATE_W'(TH_D4);
  localparam logic [RATE_W-1:0] L8 = RATE_W'(TH_D8X);
  localparam logic [RATE_W-1:0] LM = RATE_W'(TH_MIN);

  always_comb begin
    cls = '0;
    if (rate >= L1) begin
      cls.shamt = 3'd0; cls.f1 = 2'd0; cls.f0 = 2'd0;
    end else if (rate >= L2) begin
      cls.shamt = 3'd1; cls.f1 = 2'd0; cls.f0 = 2'd1;
    end else if (rate >= L4) begin
      cls.shamt = 3'd2; cls.f1 = 2'd0; cls.f0 = 2'd2;
    end else if (rate > L8) begin
      cls.shamt = 3'd3; cls.f1 = 2'd1; cls.f0 = 2'd2;
    end else if (rate >= LM) begin
      cls.shamt = 3'd4; cls.f1 = 2'd2; cls.f0 = 2'd2;
    end else begin
      cls.err = 1'b1;
    end
    cls.div_oh = cls.err ? 5'd0 : (5'd1 << cls.shamt);
  end
endmodule

// File: rtl/pllcalc_divider.sv
module pllcalc_divider #(
  parameter int unsigned DVD_W = 64,
  parameter int unsigned DEN_W = 32,
  parameter int unsigned OUT_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DVD_W-1:0] dvd,
  input  logic [DEN_W-1:0] dvs,
  output logic [OUT_W-1:0] quo,
  output logic             done
);
  localparam int unsigned CNT_W = $clog2(DVD_W + 1);

  logic [DEN_W:0]   rem_q;
  logic [DVD_W-1:0] q_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic [DEN_W:0] shifted;
  logic [DEN_W:0] rem_nx;
  logic           ge;

  always_comb begin
    shifted = {rem_q[DEN_W-1:0], q_q[DVD_W-1]};
    ge      = shifted >= {1'b0, dvs};
    rem_nx  = ge ? (shifted - {1'b0, dvs}) : shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      q_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        q_q   <= dvd;
        cnt_q <= CNT_W'(DVD_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_nx;
        q_q   <= {q_q[DVD_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quo = q_q[OUT_W-1:0];

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (rem_q < {1'b0, dvs})); // R7
endmodule

// File: rtl/pllcalc_top.sv
module pllcalc_top
  import pllcalc_pkg::*;
#(
  parameter int unsigned RATE_W   = 32,
  parameter int unsigned FCW_W    = 31,
  parameter int unsigned FRAC_W   = 24,
  parameter int unsigned DVD_W    = 64,
  parameter longint unsigned REF_HZ   = 26000000,
  parameter longint unsigned RATE_LO  = 50000000,
  parameter longint unsigned RATE_HI  = 1250000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [FCW_W-1:0]  fcw_o,
  output logic [4:0]        div_onehot_o,
  output logic [3:0]        sel_o,
  output logic [RATE_W-1:0] rounded_o
);
  localparam logic [RATE_W-1:0] REF_VAL = RATE_W'(REF_HZ);
  localparam logic [RATE_W-1:0] LO_VAL  = RATE_W'(RATE_LO);
  localparam logic [RATE_W-1:0] HI_VAL  = RATE_W'(RATE_HI);
  localparam int unsigned       BASE_SH = FRAC_W + 1;

  divsel_t            cls_in;
  divsel_t            cls_q;
  logic [RATE_W-1:0]  rate_q;
  logic               busy_q;
  logic               go_q;
  logic [DVD_W-1:0]   dvd;
  logic [FCW_W-1:0]   quo;
  logic               div_done;
  logic [RATE_W-1:0]  clamped;
  logic               accept;
  logic               finish;

  pllcalc_classify #(.RATE_W(RATE_W)) u_cls (
    .rate (rate_i),
    .cls  (cls_in)
  );

  pllcalc_divider #(.DVD_W(DVD_W), .DEN_W(RATE_W), .OUT_W(FCW_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (go_q),
    .dvd  (dvd),
    .dvs  (REF_VAL),
    .quo  (quo),
    .done (div_done)
  );

  always_comb begin
    dvd     = DVD_W'(rate_q) << (BASE_SH + int'(cls_q.shamt));
    clamped = (rate_q < LO_VAL) ? LO_VAL : ((rate_q > HI_VAL) ? HI_VAL : rate_q);
    accept  = start_i && !busy_q;
    finish  = busy_q && !go_q && (cls_q.err || div_done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q        <= '0;
      rate_q       <= '0;
      busy_q       <= 1'b0;
      go_q         <= 1'b0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      fcw_o        <= '0;
      div_onehot_o <= '0;
      sel_o        <= '0;
      rounded_o    <= '0;
    end else begin
      done_o <= 1'b0;
      go_q   <= 1'b0;
      if (accept) begin
        cls_q  <= cls_in;
        rate_q <= rate_i;
        busy_q <= 1'b1;
        go_q   <= !cls_in.err;
      end else if (finish) begin
        busy_q       <= 1'b0;
        done_o       <= 1'b1;
        err_o        <= cls_q.err;
        fcw_o        <= cls_q.err ? '0 : quo;
        div_onehot_o <= cls_q.div_oh;
        sel_o        <= cls_q.err ? 4'd0 : {cls_q.f1, cls_q.f0};
        rounded_o    <= clamped;
      end
    end
  end

  assign busy_o = busy_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> $stable(rate_q)); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (fcw_o == '0 && div_onehot_o == '0 && sel_o == '0)); // R6
  AST_DIV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> $onehot(div_onehot_o)); // R1
  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rounded_o >= LO_VAL && rounded_o <= HI_VAL)); // R8
endmodule

// File: tb/pllcalc_top_tb_top.sv
module pllcalc_top_tb_top;
  typedef struct {
    logic        err;
    logic [30:0] fcw;
    logic [4:0]  oh;
    logic [3:0]  sel;
    logic [31:0] rnd;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] rate_i = '0;
  logic        busy_o, done_o, err_o;
  logic [30:0] fcw_o;
  logic [4:0]  div_onehot_o;
  logic [3:0]  sel_o;
  logic [31:0] rounded_o;

  int total = 0;
  int bad = 0;
  int pushed = 0;
  int popped = 0;
  int cycles = 0;
  bit ended = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  pllcalc_top dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .rate_i(rate_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .fcw_o(fcw_o),
    .div_onehot_o(div_onehot_o), .sel_o(sel_o), .rounded_o(rounded_o)
  );

  task automatic chk(string req, string what, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(logic [31:0] r, string req);
    exp_t e;
    int sh;
    longint unsigned d;
    e.req = req;
    e.err = 1'b0;
    if (r >= 32'd500000000)      begin sh = 0; e.sel = 4'b0000; end
    else if (r >= 32'd250000000) begin sh = 1; e.sel = 4'b0001; end
    else if (r >= 32'd125000000) begin sh = 2; e.sel = 4'b0010; end
    else if (r > 32'd62000000)   begin sh = 3; e.sel = 4'b0110; end
    else if (r >= 32'd50000000)  begin sh = 4; e.sel = 4'b1010; end
    else begin sh = -1; e.sel = 4'b0000; e.err = 1'b1; end
    if (e.err) begin
      e.oh = '0;
      e.fcw = '0;
    end else begin
      e.oh = 5'(1 << sh);
      d = ((longint'(r) * 2 * (longint'(1) << sh)) << 24) / 64'd26000000;
      e.fcw = d[30:0];
    end
    e.rnd = (r < 32'd50000000) ? 32'd50000000 : ((r > 32'd1250000000) ? 32'd1250000000 : r);
    return e;
  endfunction

  task automatic run(logic [31:0] r, string req);
    @(negedge clk);
    while (busy_o || done_o) @(negedge clk);
    rate_i  = r;
    start_i = 1'b1;
    sb.push_back(model(r, req));
    pushed++;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9", "busy after start", longint'(busy_o), 1);
    while (busy_o) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) begin
        chk("R10", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        popped++;
        chk(e.req, "err", longint'(err_o), longint'(e.err));
        chk(e.req, "fcw", longint'(fcw_o), longint'(e.fcw));
        chk(e.req, "div_onehot", longint'(div_onehot_o), longint'(e.oh));
        chk(e.req, "sel", longint'(sel_o), longint'(e.sel));
        chk("R8", "rounded", longint'(rounded_o), longint'(e.rnd));
        chk("R9", "busy low at done", longint'(busy_o), 0);
      end
    end
  end

  // done must be a single cycle
  always @(negedge clk) begin
    if (!rst && done_o) begin
      @(negedge clk);
      chk("R9", "done width", longint'(done_o), 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !ended) begin
      ended = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "busy", longint'(busy_o), 0);
    chk("R11", "done", longint'(done_o), 0);
    chk("R11", "err", longint'(err_o), 0);
    chk("R11", "fcw", longint'(fcw_o), 0);
    chk("R11", "onehot", longint'(div_onehot_o), 0);
    chk("R11", "sel", longint'(sel_o), 0);
    chk("R11", "rounded", longint'(rounded_o), 0);

    run(32'd1250000000, "R1");
    run(32'd500000000,  "R1");
    run(32'd4000000000, "R1");
    run(32'd499999999,  "R2");
    run(32'd250000000,  "R2");
    run(32'd300000000,  "R7");
    run(32'd249999999,  "R3");
    run(32'd125000000,  "R3");
    run(32'd124999999,  "R4");
    run(32'd62000001,   "R4");
    run(32'd62000000,   "R5");
    run(32'd50000000,   "R5");
    run(32'd49999999,   "R6");
    run(32'd0,          "R6");
    run(32'd333333333,  "R7");

    // R10: a second start while busy must be ignored
    @(negedge clk);
    rate_i  = 32'd700000000;
    start_i = 1'b1;
    sb.push_back(model(32'd700000000, "R10"));
    pushed++;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rate_i  = 32'd60000000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rate_i  = 32'd0;
    while (busy_o) @(negedge clk);
    repeat (80) @(negedge clk);
    chk("R10", "results vs accepted starts", longint'(popped), longint'(pushed));
    chk("R10", "scoreboard empty", longint'(sb.size()), 0);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule